// File: doc/BRIEF.md
# Load/Store Address Generator

This block works out where a single word or byte transfer goes in memory and what the base register should hold afterwards. Each request carries the base register value, an offset (a 12-bit unsigned immediate or an offset register value already shifted elsewhere), the indexing, direction, size, writeback and load/store controls, the core's privilege state and the indices of the three registers involved. One clock later the block presents the transfer address, the size and direction strobes, a flag that asks memory to treat the transfer as unprivileged, the base writeback enable and value, and the bus cycle cost of the instruction.

The writeback control means different things in the two indexing modes. With pre-indexing it chooses whether the adjusted address returns to the base register. With post-indexing the adjusted base is always written back, and the same control instead forces the transfer to be treated as unprivileged. Register combinations that software must not use are flagged next to the transfer, which still goes out unchanged.

Top module: `ls_addr_gen`

## Requirements
- R1: While rst_n is low and on the first edge after it, acc_valid, wb_en and illegal are 0.
- R2: acc_valid equals req_valid of the previous cycle; when acc_valid is 0, wb_en and illegal are 0.
- R3: With pre_idx=1 the address is base adjusted by the offset, and it equals wb_value.
- R4: With pre_idx=0 the address is the unmodified base.
- R5: up=1 makes the adjusted value base plus offset and up=0 base minus offset, modulo 2^32.
- R6: With use_reg=0 the offset is imm_off zero-extended and reg_off is ignored; with use_reg=1 the offset is reg_off and imm_off is ignored.
- R7: wb_value is always the adjusted value; wb_en is wb_bit under pre-indexing and 1 under post-indexing.
- R8: acc_user is 1 when priv=0, or when pre_idx=0 and wb_bit=1; otherwise 0.
- R9: acc_byte equals byte_sel and acc_write equals the inverse of load.
- R10: illegal is 1 when base_idx is 15 and writeback takes place, when data_idx is 15 and byte_sel=1, or when pre_idx=0, use_reg=1 and offs_idx equals base_idx; otherwise 0, and the transfer outputs are unaffected.
- R11: A store costs 0 sequential, 2 nonsequential and 0 internal cycles; a load costs 1, 1 and 1, or 2, 2 and 1 when data_idx is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A transfer request is present |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset |
| reg_off | input | 32 | Shifted register offset |
| use_reg | input | 1 | 1 selects reg_off as the offset |
| pre_idx | input | 1 | 1 pre-indexing, 0 post-indexing |
| up | input | 1 | 1 add offset, 0 subtract |
| byte_sel | input | 1 | 1 byte transfer, 0 word |
| wb_bit | input | 1 | Writeback / forced-unprivileged control |
| load | input | 1 | 1 load, 0 store |
| priv | input | 1 | 1 when the core is privileged |
| base_idx | input | 4 | Base register index |
| data_idx | input | 4 | Data register index |
| offs_idx | input | 4 | Offset register index |
| acc_valid | output | 1 | Transfer outputs valid |
| acc_addr | output | 32 | Transfer address |
| acc_byte | output | 1 | Byte-size strobe |
| acc_write | output | 1 | Write strobe |
| acc_user | output | 1 | Treat transfer as unprivileged |
| wb_en | output | 1 | Write wb_value to the base register |
| wb_value | output | 32 | Adjusted base value |
| illegal | output | 1 | Forbidden register combination |
| cyc_seq | output | 2 | Sequential cycles of the instruction |
| cyc_nseq | output | 2 | Nonsequential cycles |
| cyc_int | output | 2 | Internal cycles |

## Verification
The checker watches on every cycle the one-cycle relation between request and result: post-indexed transfers use the raw base and always write back, pre-indexed ones put the writeback value on the bus, user mode always marks transfers unprivileged, direction and size strobes follow the request, stores cost two nonsequential cycles, a byte transfer into the program counter is flagged, and an idle cycle carries no writeback or flag. The exact arithmetic of addition and subtraction with wrap-around, that the unused offset source is ignored, the privileged forced-translation case, the base-equals-offset-register rule in both indexing modes and the reset values are shown only by the bench's vector table and directed cases.

// File: rtl/ls_addr_gen_pkg.sv
// Shared types for the load/store address generator.
// Assumes no more than three cycles of any one kind per instruction.
package ls_addr_gen_pkg;

    // Indexing mode as encoded by the pre-index control.
    typedef enum logic {
        IDX_POST = 1'b0,
        IDX_PRE  = 1'b1
    } idx_mode_e;

    // Bus cycle cost of one transfer instruction.
    typedef struct packed {
        logic [1:0] seq;
        logic [1:0] nseq;
        logic [1:0] intl;
    } cost_t;

endpackage

// File: rtl/ls_addr_gen_offset.sv
// Offset selection and address arithmetic.
// Picks the immediate (zero-extended) or the register offset, adds or
// subtracts it from the base, and chooses the adjusted or raw base as the
// transfer address according to the indexing mode. Purely combinational.
module ls_addr_gen_offset
    import ls_addr_gen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              use_reg,
    input  logic              up,
    input  idx_mode_e         mode,
    output logic [ADDR_W-1:0] adjusted,
    output logic [ADDR_W-1:0] xfer_addr
);

    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] offset;

    // Widen the immediate to the address width; the variant depends on sizes.
    generate
        if (IMM_W < ADDR_W) begin : g_imm_pad
            assign imm_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_off};
        end else begin : g_imm_trim
            assign imm_ext = imm_off[ADDR_W-1:0];
        end
    endgenerate

    // Choose the offset source and form base +/- offset.
    always_comb begin
        offset   = use_reg ? reg_off : imm_ext;
        adjusted = up ? (base_val + offset) : (base_val - offset);
    end

    // Pre-indexing uses the adjusted value, post-indexing the raw base.
    always_comb begin
        xfer_addr = (mode == IDX_PRE) ? adjusted : base_val;
    end

endmodule

// File: rtl/ls_addr_gen_ctrl.sv
// Control decode for a single transfer.
// Derives writeback enable, unprivileged-access flag, size and direction
// strobes, and the bus cycle cost. Assumes the highest register index is
// the program counter. Purely combinational.
module ls_addr_gen_ctrl
    import ls_addr_gen_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  idx_mode_e        mode,
    input  logic             wb_bit,
    input  logic             byte_sel,
    input  logic             load,
    input  logic             priv,
    input  logic [IDX_W-1:0] data_idx,
    output logic             wb_en,
    output logic             user_acc,
    output logic             byte_acc,
    output logic             write_acc,
    output cost_t            cost
);

    localparam logic [IDX_W-1:0] PC_IDX = '1;

    logic data_is_pc;

    // Writeback and privilege: the writeback control changes meaning with mode.
    always_comb begin
        if (mode == IDX_PRE) begin
            wb_en    = wb_bit;
            user_acc = !priv;
        end else begin
            wb_en    = 1'b1;
            user_acc = !priv || wb_bit;
        end
    end

    // Size and direction strobes follow the request directly.
    always_comb begin
        byte_acc  = byte_sel;
        write_acc = !load;
    end

    // Cycle cost: stores two nonsequential, loads add a refill when PC is loaded.
    always_comb begin
        data_is_pc = (data_idx == PC_IDX);
        if (!load) begin
            cost = '{seq: 2'd0, nseq: 2'd2, intl: 2'd0};
        end else if (data_is_pc) begin
            cost = '{seq: 2'd2, nseq: 2'd2, intl: 2'd1};
        end else begin
            cost = '{seq: 2'd1, nseq: 2'd1, intl: 2'd1};
        end
    end

endmodule

// File: rtl/ls_addr_gen_rules.sv
// Detection of forbidden register combinations.
// Flags a PC base with writeback, a PC data register on a byte transfer,
// and a post-indexed register offset sharing the base register. The flag is
// advisory; it does not alter the transfer. Purely combinational.
module ls_addr_gen_rules
    import ls_addr_gen_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  idx_mode_e        mode,
    input  logic             use_reg,
    input  logic             byte_sel,
    input  logic             wb_en,
    input  logic [IDX_W-1:0] base_idx,
    input  logic [IDX_W-1:0] data_idx,
    input  logic [IDX_W-1:0] offs_idx,
    output logic             illegal
);

    localparam logic [IDX_W-1:0] PC_IDX = '1;
    localparam int               N_RULE = 3;

    logic [N_RULE-1:0] hit;

    // Evaluate each rule separately, then merge.
    always_comb begin
        hit[0]  = (base_idx == PC_IDX) && wb_en;
        hit[1]  = (data_idx == PC_IDX) && byte_sel;
        hit[2]  = (mode == IDX_POST) && use_reg && (offs_idx == base_idx);
        illegal = |hit;
    end

endmodule

// File: rtl/ls_addr_gen.sv
// Load/store address generator, top level.
// Registers one transfer per cycle: address, strobes, unprivileged flag,
// writeback and cost appear one clock after the request. Assumes the
// offset register value arrives already shifted. Synchronous active-low reset.
module ls_addr_gen
    import ls_addr_gen_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 12,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              use_reg,
    input  logic              pre_idx,
    input  logic              up,
    input  logic              byte_sel,
    input  logic              wb_bit,
    input  logic              load,
    input  logic              priv,
    input  logic [IDX_W-1:0]  base_idx,
    input  logic [IDX_W-1:0]  data_idx,
    input  logic [IDX_W-1:0]  offs_idx,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              acc_byte,
    output logic              acc_write,
    output logic              acc_user,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_value,
    output logic              illegal,
    output logic [1:0]        cyc_seq,
    output logic [1:0]        cyc_nseq,
    output logic [1:0]        cyc_int
);

    idx_mode_e         mode;
    logic [ADDR_W-1:0] adjusted;
    logic [ADDR_W-1:0] xfer_addr;
    logic              wb_c;
    logic              user_c;
    logic              byte_c;
    logic              write_c;
    logic              illegal_c;
    cost_t             cost_c;

    assign mode = idx_mode_e'(pre_idx);

    ls_addr_gen_offset #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) offset_i (
        .base_val  (base_val),
        .imm_off   (imm_off),
        .reg_off   (reg_off),
        .use_reg   (use_reg),
        .up        (up),
        .mode      (mode),
        .adjusted  (adjusted),
        .xfer_addr (xfer_addr)
    );

    ls_addr_gen_ctrl #(
        .IDX_W (IDX_W)
    ) ctrl_i (
        .mode      (mode),
        .wb_bit    (wb_bit),
        .byte_sel  (byte_sel),
        .load      (load),
        .priv      (priv),
        .data_idx  (data_idx),
        .wb_en     (wb_c),
        .user_acc  (user_c),
        .byte_acc  (byte_c),
        .write_acc (write_c),
        .cost      (cost_c)
    );

    ls_addr_gen_rules #(
        .IDX_W (IDX_W)
    ) rules_i (
        .mode     (mode),
        .use_reg  (use_reg),
        .byte_sel (byte_sel),
        .wb_en    (wb_c),
        .base_idx (base_idx),
        .data_idx (data_idx),
        .offs_idx (offs_idx),
        .illegal  (illegal_c)
    );

    // Valid and its qualified side effects clear on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_valid <= 1'b0;
            wb_en     <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            acc_valid <= req_valid;
            wb_en     <= req_valid && wb_c;
            illegal   <= req_valid && illegal_c;
        end
    end

    // Transfer data registers capture on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr  <= '0;
            acc_byte  <= 1'b0;
            acc_write <= 1'b0;
            acc_user  <= 1'b0;
            wb_value  <= '0;
            cyc_seq   <= '0;
            cyc_nseq  <= '0;
            cyc_int   <= '0;
        end else if (req_valid) begin
            acc_addr  <= xfer_addr;
            acc_byte  <= byte_c;
            acc_write <= write_c;
            acc_user  <= user_c;
            wb_value  <= adjusted;
            cyc_seq   <= cost_c.seq;
            cyc_nseq  <= cost_c.nseq;
            cyc_int   <= cost_c.intl;
        end
    end

endmodule

// File: rtl/ls_addr_gen_chk.sv
// Property checker for the load/store address generator, bound to the top.
// Relates each request to the registered result one cycle later.
module ls_addr_gen_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] base_val,
    input logic              pre_idx,
    input logic              byte_sel,
    input logic              wb_bit,
    input logic              load,
    input logic              priv,
    input logic [IDX_W-1:0]  data_idx,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_byte,
    input logic              acc_write,
    input logic              acc_user,
    input logic              wb_en,
    input logic [ADDR_W-1:0] wb_value,
    input logic              illegal,
    input logic [1:0]        cyc_seq,
    input logic [1:0]        cyc_nseq,
    input logic [1:0]        cyc_int
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> acc_valid); // R2
    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !acc_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |-> (!wb_en && !illegal)); // R2
    AST_PRE_ADDR_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pre_idx) |=> (acc_addr == wb_value)); // R3
    AST_POST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pre_idx) |=> (acc_addr == $past(base_val))); // R4
    AST_POST_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pre_idx) |=> wb_en); // R7
    AST_PRE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pre_idx && !wb_bit) |=> !wb_en); // R7
    AST_USER_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !priv) |=> acc_user); // R8
    AST_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((acc_write == !$past(load)) && (acc_byte == $past(byte_sel)))); // R9
    AST_PC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && byte_sel && (data_idx == '1)) |=> illegal); // R10
    AST_STORE_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !load) |=> (cyc_seq == 2'd0 && cyc_nseq == 2'd2 && cyc_int == 2'd0)); // R11

endmodule

bind ls_addr_gen ls_addr_gen_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) chk_i (.*);

// File: tb/ls_addr_gen_tb_top.sv
`timescale 1ns/1ps
module ls_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        use_reg = 1'b0, pre_idx = 1'b0, up = 1'b0, byte_sel = 1'b0;
    logic        wb_bit = 1'b0, load = 1'b0, priv = 1'b0;
    logic [3:0]  base_idx = '0, data_idx = '0, offs_idx = '0;
    logic        acc_valid, acc_byte, acc_write, acc_user, wb_en, illegal;
    logic [31:0] acc_addr, wb_value;
    logic [1:0]  cyc_seq, cyc_nseq, cyc_int;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    ls_addr_gen dut_i (.*);

    typedef struct packed {
        logic        pre, up, byt, wbb, ld, priv, ureg;
        logic [31:0] base;
        logic [11:0] imm;
        logic [31:0] roff;
        logic [3:0]  bidx, didx, oidx;
        logic [31:0] e_addr;
        logic        e_wb;
        logic [31:0] e_wbv;
        logic        e_user, e_ill;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        // pre up word, imm form ignores reg_off
        '{1,1,0,0,1,1,0, 32'h1000, 12'h004, 32'hDEADBEEF, 4'd1, 4'd2, 4'd3, 32'h1004, 1'b0, 32'h1004, 1'b0, 1'b0},
        // pre down, writeback, full immediate
        '{1,0,0,1,0,1,0, 32'h2000, 12'hFFF, 32'hDEADBEEF, 4'd1, 4'd2, 4'd3, 32'h1001, 1'b1, 32'h1001, 1'b0, 1'b0},
        // post up, register form ignores imm
        '{0,1,0,0,1,1,1, 32'h3000, 12'hABC, 32'h00000100, 4'd1, 4'd3, 4'd2, 32'h3000, 1'b1, 32'h3100, 1'b0, 1'b0},
        // post down with forced unprivileged access
        '{0,0,0,1,0,1,0, 32'h4000, 12'h010, 32'hDEADBEEF, 4'd1, 4'd2, 4'd3, 32'h4000, 1'b1, 32'h3FF0, 1'b1, 1'b0},
        // user mode byte load
        '{1,1,1,0,1,0,0, 32'h5003, 12'h000, 32'hDEADBEEF, 4'd1, 4'd3, 4'd2, 32'h5003, 1'b0, 32'h5003, 1'b1, 1'b0},
        // PC base with writeback
        '{1,1,0,1,1,1,0, 32'h0008, 12'h004, 32'h0, 4'd15, 4'd2, 4'd3, 32'h000C, 1'b1, 32'h000C, 1'b0, 1'b1},
        // byte store from PC
        '{1,1,1,0,0,1,0, 32'h0100, 12'h001, 32'h0, 4'd1, 4'd15, 4'd3, 32'h0101, 1'b0, 32'h0101, 1'b0, 1'b1},
        // post register offset equal to base, wrap to zero
        '{0,1,0,0,1,1,1, 32'h0010, 12'h000, 32'hFFFFFFF0, 4'd4, 4'd2, 4'd4, 32'h0010, 1'b1, 32'h0000, 1'b0, 1'b1},
        // pre register offset equal to base is legal, wrap below zero
        '{1,0,0,0,1,1,1, 32'h0010, 12'h000, 32'h00000020, 4'd4, 4'd2, 4'd4, 32'hFFFFFFF0, 1'b0, 32'hFFFFFFF0, 1'b0, 1'b0},
        // post imm form with matching offset index is legal
        '{0,1,0,0,0,1,0, 32'h0020, 12'h008, 32'h0, 4'd5, 4'd6, 4'd5, 32'h0020, 1'b1, 32'h0028, 1'b0, 1'b0},
        // word load into PC
        '{1,1,0,0,1,1,0, 32'h0040, 12'h000, 32'h0, 4'd1, 4'd15, 4'd2, 32'h0040, 1'b0, 32'h0040, 1'b0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        pre_idx = v.pre; up = v.up; byte_sel = v.byt; wb_bit = v.wbb;
        load = v.ld; priv = v.priv; use_reg = v.ureg;
        base_val = v.base; imm_off = v.imm; reg_off = v.roff;
        base_idx = v.bidx; data_idx = v.didx; offs_idx = v.oidx;
    endtask

    task automatic check_vec(input vec_t v);
        logic [5:0] exp_cost;
        if (!v.ld)                 exp_cost = {2'd0, 2'd2, 2'd0};
        else if (v.didx == 4'd15)  exp_cost = {2'd2, 2'd2, 2'd1};
        else                       exp_cost = {2'd1, 2'd1, 2'd1};
        chk("R2 valid", 32'(acc_valid), 32'd1);
        chk("R3/R4/R5/R6 addr", acc_addr, v.e_addr);
        chk("R7 wb_en", 32'(wb_en), 32'(v.e_wb));
        chk("R7 wb_value", wb_value, v.e_wbv);
        chk("R8 user", 32'(acc_user), 32'(v.e_user));
        chk("R9 byte", 32'(acc_byte), 32'(v.byt));
        chk("R9 write", 32'(acc_write), 32'(!v.ld));
        chk("R10 illegal", 32'(illegal), 32'(v.e_ill));
        chk("R11 cost", 32'({cyc_seq, cyc_nseq, cyc_int}), 32'(exp_cost));
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, with a request pending during reset
        req_valid = 1'b1; wb_bit = 1'b1; byte_sel = 1'b1; data_idx = 4'd15;
        repeat (3) @(negedge clk);
        chk("R1 acc_valid in reset", 32'(acc_valid), 32'd0);
        chk("R1 wb_en in reset", 32'(wb_en), 32'd0);
        chk("R1 illegal in reset", 32'(illegal), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 acc_valid after reset", 32'(acc_valid), 32'd0);
        chk("R1 wb_en after reset", 32'(wb_en), 32'd0);

        // Vector table: one request per cycle, checked the following cycle
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i]);
        end

        // R2: idle cycle after a post-indexed illegal request clears side effects
        drive(VECS[7]);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R2 idle valid", 32'(acc_valid), 32'd0);
        chk("R2 idle wb_en", 32'(wb_en), 32'd0);
        chk("R2 idle illegal", 32'(illegal), 32'd0);

        // R8: privileged pre-index with writeback bit stays privileged
        drive('{1,1,0,1,1,1,0, 32'h0, 12'h0, 32'h0, 4'd1, 4'd2, 4'd3, 32'h0, 1'b1, 32'h0, 1'b0, 1'b0});
        @(negedge clk);
        chk("R8 pre wb privileged user", 32'(acc_user), 32'd0);
        chk("R7 pre wb enable", 32'(wb_en), 32'd1);

        // R1: reset asserted mid-stream clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset valid", 32'(acc_valid), 32'd0);
        chk("R1 mid-run reset wb_en", 32'(wb_en), 32'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule